// File: doc/BRIEF.md
# Scan-Controlled Chip Reset Controller

This block is the test-port slice of a chip that lets a scan host hold the whole device in reset. It contains the sixteen-state test access port sequencer, a 4-bit instruction register, a one-bit bypass path, a one-bit scan reset register and the steering for an external boundary-scan chain. When the scan reset instruction is active, the bit shifted into the one-bit register drives the chip reset straight away. There is no update stage, so the reset starts in the same TCK cycle that shifts in the 1.

The scan reset is ORed with the system reset and with a vector of other reset requests. The result is then held asserted for a programmable number of system clocks after the last source goes away. The same combined reset forces every port pin to high impedance. This lets the scan reset instruction also serve as a "float all pins" instruction.

The host drives TCK, TMS, TDI and the synchronous active-low trst_n. System-side requests are synchronous to sys_clk. The scan reset crosses into sys_clk through a short synchronizer, which only restarts the stretch counter. The reset output itself reacts to the raw scan bit with no delay.

Top module: `jrst_ctrl`

## Requirements
- R1: The sequencer follows the standard sixteen-state TMS diagram. Five TCK rising edges with TMS high reach Test-Logic-Reset from any state. trst_n low at a TCK rising edge also forces Test-Logic-Reset.
- R2: In Test-Logic-Reset, or with trst_n low, the instruction register loads BYPASS (4'hF) and the scan reset register clears to 0.
- R3: Capture-IR loads 4'b0001. Every shift path moves its least significant bit out on TDO first and takes TDI into its most significant bit.
- R4: Opcode decode works as follows. 4'h0 selects the boundary chain: bs_sel_o is high and TDO follows ext_tdo_i. 4'hC selects the one-bit scan reset register. Every other code selects the one-bit bypass register, which captures 0 in Capture-DR.
- R5: With opcode 4'hC active, the scan reset register loads TDI at each TCK rising edge in Shift-DR and at no other time. A 1 raises int_rst_o right after that edge, before Update-DR.
- R6: The scan reset register keeps its value while other instructions are loaded. Reset stays asserted throughout, and the held value is shifted out on the next reset-register scan.
- R7: int_rst_o is high whenever sys_rst_n is low, any bit of rst_req_i is high, or the scan reset register holds 1.
- R8: After every source is gone, int_rst_o stays high for N sys_clk rising edges. N is 0, 16, 256 or 4096 for tmo_sel_i equal to 0, 1, 2 or 3. A source that returns during the count restarts it.
- R9: pins_hiz_o is high exactly when int_rst_o is high.
- R10: TDO and tdo_en_o change on the falling edge of TCK. tdo_en_o is high only while the sequencer is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test logic reset, active low, synchronous to tck |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out, falling-edge timed |
| tdo_en_o | output | 1 | TDO driver enable |
| ext_tdo_i | input | 1 | Serial output of the external boundary chain |
| bs_sel_o | output | 1 | Boundary chain is the selected data path |
| bs_capture_o | output | 1 | Boundary chain capture strobe (Capture-DR) |
| bs_shift_o | output | 1 | Boundary chain shift enable (Shift-DR) |
| bs_update_o | output | 1 | Boundary chain update strobe (Update-DR) |
| sys_clk | input | 1 | System clock that times the reset stretch |
| sys_rst_n | input | 1 | System reset, active low, synchronous to sys_clk |
| rst_req_i | input | REQ_W | Other reset requests, active high |
| tmo_sel_i | input | 2 | Stretch length select |
| int_rst_o | output | 1 | Combined internal reset |
| pins_hiz_o | output | 1 | Forces port pins to high impedance |

## Verification
A wrong sequencer state shows up within one TCK cycle. The captured instruction pattern, the one-bit delay of the bypass path or tdo_en_o would come out wrong during the very next shift. A decode error shows on the next data scan: the wrong TDO stream, a wrong bs_sel_o, or int_rst_o failing to follow the last bit shifted. A wrong stretch counter is only visible at the release of int_rst_o. The bench measures the release edge in sys_clk cycles for every timeout setting, including a restart in the middle of a count.

// File: rtl/jrst_pkg.sv
// Shared types and constants for the scan reset controller.
package jrst_pkg;

    // Test access port sequencer states
    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
    } tap_state_t;

    // Data path placed between TDI and TDO
    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_SCANRST,
        PATH_BOUNDARY
    } dr_path_t;

    localparam int          IR_W        = 4;
    localparam logic [IR_W-1:0] OPC_EXTEST  = 4'h0;
    localparam logic [IR_W-1:0] OPC_SCANRST = 4'hC;
    localparam logic [IR_W-1:0] OPC_BYPASS  = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

endpackage

// File: rtl/jrst_tap_fsm.sv
// Test access port sequencer.
// Walks the sixteen-state TMS diagram on rising TCK edges.
// Assumes: trst_n is synchronous to tck and active low.
module jrst_tap_fsm
    import jrst_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state_o
);

    tap_state_t state_q;
    tap_state_t state_d;

    // Next-state decode from the current state and TMS
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     state_d = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   state_d = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: state_d = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: state_d = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: state_d = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   state_d = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: state_d = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: state_d = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: state_d = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
            default:     state_d = TS_RESET;
        endcase
    end

    // State register with synchronous test reset
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            state_q <= TS_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/jrst_ir.sv
// Instruction register with capture/shift stage and decode.
// Captures a fixed pattern, shifts LSB first, and loads the active
// instruction on Update-IR. Test-Logic-Reset selects BYPASS.
// Assumes: trst_n synchronous to tck.
module jrst_ir
    import jrst_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_t      state_i,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_o,
    output logic            ir_tdo_o,
    output dr_path_t        path_o
);

    logic [IR_W-1:0] sr_q;
    logic [IR_W-1:0] ir_q;

    // Capture/shift stage of the instruction register
    always_ff @(posedge tck) begin
        if (!trst_n || state_i == TS_RESET) begin
            sr_q <= IR_CAPTURE;
        end else if (state_i == TS_CAP_IR) begin
            sr_q <= IR_CAPTURE;
        end else if (state_i == TS_SHIFT_IR) begin
            sr_q <= {tdi, sr_q[IR_W-1:1]};
        end
    end

    // Active instruction, loaded on Update-IR
    always_ff @(posedge tck) begin
        if (!trst_n || state_i == TS_RESET) begin
            ir_q <= OPC_BYPASS;
        end else if (state_i == TS_UPD_IR) begin
            ir_q <= sr_q;
        end
    end

    // Opcode decode; undefined codes fall back to bypass
    always_comb begin
        unique case (ir_q)
            OPC_EXTEST:  path_o = PATH_BOUNDARY;
            OPC_SCANRST: path_o = PATH_SCANRST;
            default:     path_o = PATH_BYPASS;
        endcase
    end

    assign ir_o     = ir_q;
    assign ir_tdo_o = sr_q[0];

endmodule

// File: rtl/jrst_dr.sv
// Data registers: one-bit bypass and one-bit scan reset register.
// The scan reset register has no update latch; its flip-flop output
// is the scan reset request itself.
// Assumes: trst_n synchronous to tck; ext_tdo_i is the boundary chain output.
module jrst_dr
    import jrst_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_t state_i,
    input  dr_path_t   path_i,
    input  logic       tdi,
    input  logic       ext_tdo_i,
    output logic       scan_rst_o,
    output logic       dr_tdo_o
);

    logic byp_q;
    logic srst_q;

    // Bypass bit: captures 0, then shifts TDI
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (path_i == PATH_BYPASS && state_i == TS_CAP_DR) begin
            byp_q <= 1'b0;
        end else if (path_i == PATH_BYPASS && state_i == TS_SHIFT_DR) begin
            byp_q <= tdi;
        end
    end

    // Scan reset bit: clocked only in Shift-DR with its instruction active
    always_ff @(posedge tck) begin
        if (!trst_n || state_i == TS_RESET) begin
            srst_q <= 1'b0;
        end else if (path_i == PATH_SCANRST && state_i == TS_SHIFT_DR) begin
            srst_q <= tdi;
        end
    end

    // Serial output select for the data side
    always_comb begin
        unique case (path_i)
            PATH_SCANRST:  dr_tdo_o = srst_q;
            PATH_BOUNDARY: dr_tdo_o = ext_tdo_i;
            default:       dr_tdo_o = byp_q;
        endcase
    end

    assign scan_rst_o = srst_q;

endmodule

// File: rtl/jrst_stretch.sv
// Reset combiner and release stretcher in the system clock domain.
// ORs all reset sources and keeps the result high for a selected
// number of sys_clk cycles after the last source drops.
// Assumes: rst_req_i and tmo_sel_i synchronous to sys_clk; scan_rst_i
// comes from the tck domain and is synchronized only for the counter.
module jrst_stretch #(
    parameter int REQ_W       = 2,
    parameter int STEP_LOG2   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = 3 * STEP_LOG2 + 1
) (
    input  logic             sys_clk,
    input  logic             sys_rst_n,
    input  logic             scan_rst_i,
    input  logic [REQ_W-1:0] rst_req_i,
    input  logic [1:0]       tmo_sel_i,
    output logic             int_rst_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             reload_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [CNT_W-1:0]       load_val;
    logic                   reload;

    // Stretch length: zero, or 2^(sel*STEP_LOG2)
    always_comb begin
        if (tmo_sel_i == 2'd0) begin
            load_val = '0;
        end else begin
            load_val = CNT_W'(1) << (32'(tmo_sel_i) * STEP_LOG2);
        end
    end

    // Synchronizer for the scan reset into sys_clk
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], scan_rst_i};
        end
    end

    assign reload = !sys_rst_n || (|rst_req_i) || (|sync_q);

    // Down-counter restarted by any active source
    always_ff @(posedge sys_clk) begin
        if (reload) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign int_rst_o = !sys_rst_n || (|rst_req_i) || scan_rst_i || (|sync_q) || (cnt_q != '0);
    assign cnt_o     = cnt_q;
    assign reload_o  = reload;

endmodule

// File: rtl/jrst_ctrl.sv
// Top of the scan reset controller.
// Joins the sequencer, instruction register, data registers and the
// reset stretcher; times TDO on the falling edge of TCK and drives
// the boundary chain strobes.
// Assumes: boundary cells live outside and use the bs_* strobes.
module jrst_ctrl
    import jrst_pkg::*;
#(
    parameter int REQ_W       = 2,
    parameter int STEP_LOG2   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = 3 * STEP_LOG2 + 1
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo_o,
    output logic             tdo_en_o,
    input  logic             ext_tdo_i,
    output logic             bs_sel_o,
    output logic             bs_capture_o,
    output logic             bs_shift_o,
    output logic             bs_update_o,
    input  logic             sys_clk,
    input  logic             sys_rst_n,
    input  logic [REQ_W-1:0] rst_req_i,
    input  logic [1:0]       tmo_sel_i,
    output logic             int_rst_o,
    output logic             pins_hiz_o
);

    tap_state_t      tap_state;
    logic [IR_W-1:0] ir_q;
    logic            ir_tdo;
    dr_path_t        path;
    logic            scan_rst_q;
    logic            dr_tdo;
    logic [CNT_W-1:0] stretch_cnt;
    logic            stretch_reload;
    logic            tdo_q;
    logic            tdo_en_q;

    jrst_tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (tap_state)
    );

    jrst_ir u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .state_i  (tap_state),
        .tdi      (tdi),
        .ir_o     (ir_q),
        .ir_tdo_o (ir_tdo),
        .path_o   (path)
    );

    jrst_dr u_dr (
        .tck        (tck),
        .trst_n     (trst_n),
        .state_i    (tap_state),
        .path_i     (path),
        .tdi        (tdi),
        .ext_tdo_i  (ext_tdo_i),
        .scan_rst_o (scan_rst_q),
        .dr_tdo_o   (dr_tdo)
    );

    jrst_stretch #(
        .REQ_W       (REQ_W),
        .STEP_LOG2   (STEP_LOG2),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_stretch (
        .sys_clk    (sys_clk),
        .sys_rst_n  (sys_rst_n),
        .scan_rst_i (scan_rst_q),
        .rst_req_i  (rst_req_i),
        .tmo_sel_i  (tmo_sel_i),
        .int_rst_o  (int_rst_o),
        .cnt_o      (stretch_cnt),
        .reload_o   (stretch_reload)
    );

    // TDO and its enable, retimed to the falling edge of TCK
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo_q    <= 1'b0;
            tdo_en_q <= 1'b0;
        end else begin
            tdo_q    <= (tap_state == TS_SHIFT_IR) ? ir_tdo : dr_tdo;
            tdo_en_q <= (tap_state == TS_SHIFT_IR) || (tap_state == TS_SHIFT_DR);
        end
    end

    assign tdo_o        = tdo_q;
    assign tdo_en_o     = tdo_en_q;
    assign bs_sel_o     = (path == PATH_BOUNDARY);
    assign bs_capture_o = bs_sel_o && (tap_state == TS_CAP_DR);
    assign bs_shift_o   = bs_sel_o && (tap_state == TS_SHIFT_DR);
    assign bs_update_o  = bs_sel_o && (tap_state == TS_UPD_DR);
    assign pins_hiz_o   = int_rst_o;

endmodule

// File: rtl/jrst_ctrl_chk.sv
// Property checker for jrst_ctrl, attached with bind below.
module jrst_ctrl_chk
    import jrst_pkg::*;
#(
    parameter int REQ_W = 2,
    parameter int CNT_W = 13
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tms,
    input logic             sys_clk,
    input logic             sys_rst_n,
    input logic [REQ_W-1:0] rst_req_i,
    input logic             int_rst_o,
    input logic             tdo_en_o,
    input tap_state_t       tap_state,
    input logic [IR_W-1:0]  ir_q,
    input dr_path_t         path,
    input logic             scan_rst_q,
    input logic [CNT_W-1:0] stretch_cnt,
    input logic             stretch_reload
);

    // R1: five TMS-high edges reach Test-Logic-Reset
    a_r1_five_tms_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (tap_state == TS_RESET));

    // R2: Test-Logic-Reset loads BYPASS and clears the scan reset bit
    a_r2_reset_state: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == TS_RESET) |=> (ir_q == OPC_BYPASS && !scan_rst_q));

    // R5: scan reset bit changes only in Shift-DR under its instruction
    a_r5_scan_bit_gated: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(scan_rst_q) |->
        (($past(tap_state) == TS_SHIFT_DR && $past(path) == PATH_SCANRST)
         || $past(tap_state) == TS_RESET || !$past(trst_n)));

    // R10: TDO enable only during the shift states
    a_r10_tdo_enable: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en_o |-> (tap_state == TS_SHIFT_DR || tap_state == TS_SHIFT_IR));

    // R7: any request forces the internal reset
    a_r7_request_forces: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (|rst_req_i) |-> int_rst_o);

    // R8: idle counter decrements by exactly one per cycle
    a_r8_count_down: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (stretch_cnt != '0 && !stretch_reload) |=> (stretch_cnt == $past(stretch_cnt) - 1'b1));

    // R8: release only when every source is gone and the count is spent
    a_r8_clean_release: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $fell(int_rst_o) |-> (stretch_cnt == '0 && rst_req_i == '0 && !scan_rst_q));

endmodule

bind jrst_ctrl jrst_ctrl_chk #(
    .REQ_W (REQ_W),
    .CNT_W (CNT_W)
) u_chk (
    .tck            (tck),
    .trst_n         (trst_n),
    .tms            (tms),
    .sys_clk        (sys_clk),
    .sys_rst_n      (sys_rst_n),
    .rst_req_i      (rst_req_i),
    .int_rst_o      (int_rst_o),
    .tdo_en_o       (tdo_en_o),
    .tap_state      (tap_state),
    .ir_q           (ir_q),
    .path           (path),
    .scan_rst_q     (scan_rst_q),
    .stretch_cnt    (stretch_cnt),
    .stretch_reload (stretch_reload)
);

// File: tb/tb_jrst_ctrl.sv
module tb_jrst_ctrl;

    localparam int REQ_W = 2;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo_o, tdo_en_o, ext_tdo_i = 1'b0;
    logic bs_sel_o, bs_capture_o, bs_shift_o, bs_update_o;
    logic sys_clk = 1'b0, sys_rst_n = 1'b0;
    logic [REQ_W-1:0] rst_req_i = '0;
    logic [1:0] tmo_sel_i = 2'd0;
    logic int_rst_o, pins_hiz_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic tdo_s;
    bit done = 0;

    always #10 sys_clk = ~sys_clk;

    jrst_ctrl #(.REQ_W(REQ_W)) dut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One TCK period: drive, sample TDO before the rise, fall later
    task automatic tap_cycle(input logic m, input logic d);
        tms = m; tdi = d;
        #20;
        tdo_s = tdo_o;
        tck = 1'b1;
        #50;
        tck = 1'b0;
        #30;
    endtask

    task automatic goto_idle();
        for (int i = 0; i < 5; i++) tap_cycle(1'b1, 1'b0);
        tap_cycle(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
        tap_cycle(1, 0); tap_cycle(1, 0); tap_cycle(0, 0); tap_cycle(0, 0);
        for (int i = 0; i < 4; i++) begin
            tap_cycle(i == 3, op[i]);
            cap[i] = tdo_s;
        end
        tap_cycle(1, 0); tap_cycle(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [7:0] d, output logic [7:0] q);
        q = '0;
        tap_cycle(1, 0); tap_cycle(0, 0); tap_cycle(0, 0);
        for (int i = 0; i < n; i++) begin
            tap_cycle(i == n - 1, d[i]);
            q[i] = tdo_s;
        end
        tap_cycle(1, 0); tap_cycle(0, 0);
    endtask

    // Counts sys_clk cycles until int_rst_o is seen low (sampled after negedges)
    task automatic measure_release(output int k);
        k = 0;
        #1;
        while (int_rst_o && k < 6000) begin
            @(negedge sys_clk);
            #1;
            k++;
        end
    endtask

    task automatic settle(input int cycles);
        for (int i = 0; i < cycles; i++) @(negedge sys_clk);
        #1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] cap;
        logic [7:0] q;
        int k;

        // Reset state
        for (int i = 0; i < 3; i++) tap_cycle(1, 0);
        settle(2);
        check("R7 sys reset drives int_rst", int'(int_rst_o), 1);
        check("R9 hiz follows reset", int'(pins_hiz_o), 1);
        check("R10 tdo_en low in reset", int'(tdo_en_o), 0);
        check("R2 bs_sel low after reset", int'(bs_sel_o), 0);
        @(negedge sys_clk); sys_rst_n = 1'b1; trst_n = 1'b1;
        #1;
        check("R8 zero stretch release", int'(int_rst_o), 0);
        check("R9 hiz low with reset low", int'(pins_hiz_o), 0);
        goto_idle();

        // R3: capture pattern
        load_ir(4'hF, cap);
        check("R3 IR capture pattern", int'(cap), 1);

        // R4: bypass delays by one bit, captures 0
        scan_dr(8, 8'hA5, q);
        check("R4 bypass stream", int'(q), int'({8'hA5, 1'b0} & 8'hFF));

        // R10: enable during Shift-DR
        tap_cycle(1, 0); tap_cycle(0, 0); tap_cycle(0, 0);
        check("R10 tdo_en in Shift-DR", int'(tdo_en_o), 1);
        tap_cycle(1, 0); tap_cycle(1, 0); tap_cycle(0, 0);
        check("R10 tdo_en low in Idle", int'(tdo_en_o), 0);

        // R4/R5: sweep all opcodes
        ext_tdo_i = 1'b1;
        for (int op = 0; op < 16; op++) begin
            load_ir(4'(op), cap);
            check("R3 capture during sweep", int'(cap), 1);
            check("R4 bs_sel decode", int'(bs_sel_o), int'(op == 0));
            scan_dr(4, 8'h0B, q);
            check("R4 path stream", int'(q[3:0]), (op == 0) ? 15 : 6);
            check("R5 reset follows last bit", int'(int_rst_o), int'(op == 12));
            if (op == 12) begin
                scan_dr(1, 8'h00, q);
                check("R5 held bit shifted out", int'(q[0]), 1);
                settle(6);
                check("R8 release after clear", int'(int_rst_o), 0);
            end
        end
        ext_tdo_i = 1'b0;

        // R5: reset rises before Update-DR; R6 hold across instructions
        load_ir(4'hC, cap);
        tap_cycle(1, 0); tap_cycle(0, 0); tap_cycle(0, 0);
        tap_cycle(1, 1);
        #1;
        check("R5 reset in Exit1-DR", int'(int_rst_o), 1);
        tap_cycle(1, 0); tap_cycle(0, 0);
        load_ir(4'hF, cap);
        settle(40);
        check("R6 reset held under bypass", int'(int_rst_o), 1);
        check("R9 hiz held", int'(pins_hiz_o), 1);
        tmo_sel_i = 2'd1;
        load_ir(4'hC, cap);
        tap_cycle(1, 0); tap_cycle(0, 0); tap_cycle(0, 0);
        tap_cycle(0, 0);
        check("R6 held value on TDO", int'(tdo_s), 1);
        measure_release(k);
        check("R8 scan release window", int'(k >= 12 && k <= 19), 1);
        tap_cycle(1, 0); tap_cycle(1, 0); tap_cycle(0, 0);

        // R2: TMS reset clears the scan bit
        tmo_sel_i = 2'd0;
        scan_dr(1, 8'h01, q);
        check("R5 set again", int'(int_rst_o), 1);
        for (int i = 0; i < 5; i++) tap_cycle(1, 0);
        settle(6);
        check("R2 TLR clears scan reset", int'(int_rst_o), 0);
        tap_cycle(0, 0);

        // R1/R2: trst_n returns IR to BYPASS
        load_ir(4'h0, cap);
        check("R4 extest selected", int'(bs_sel_o), 1);
        trst_n = 1'b0; tap_cycle(0, 0); trst_n = 1'b1;
        check("R1 trst_n resets IR", int'(bs_sel_o), 0);
        tap_cycle(0, 0);

        // R7/R8: each request bit, every stretch length
        for (int b = 0; b < REQ_W; b++) begin
            @(negedge sys_clk); rst_req_i = REQ_W'(1) << b; #1;
            check("R7 request bit forces reset", int'(int_rst_o), 1);
            @(negedge sys_clk); rst_req_i = '0;
            settle(2);
        end
        for (int s = 0; s < 4; s++) begin
            tmo_sel_i = 2'(s);
            @(negedge sys_clk); rst_req_i = 2'b01;
            settle(3);
            rst_req_i = '0;
            measure_release(k);
            check("R8 stretch length", k, (s == 0) ? 0 : (1 << (4 * s)));
        end

        // R8: restart during the count
        tmo_sel_i = 2'd1;
        @(negedge sys_clk); rst_req_i = 2'b10;
        settle(3);
        rst_req_i = '0;
        settle(8);
        check("R8 mid-count still high", int'(int_rst_o), 1);
        rst_req_i = 2'b10;
        @(negedge sys_clk); rst_req_i = '0;
        measure_release(k);
        check("R8 restart length", k, 16);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule